// File: doc/BRIEF.md
# Single-Pin Delivery Acknowledge Tracker

This block follows one interrupt pin that is delivered to several destinations and keeps count of the acknowledges still owed for it. When a delivery goes out, the requester presents the set of destinations that took the interrupt and the vector that was sent. The tracker records one bit per accepting destination, stores the vector against each of those destinations, and loads a pending count equal to the number of accepting destinations. Which destinations accept is decided outside the block.

Acknowledges arrive as a destination index plus a vector. An acknowledge retires a destination only when that destination is still marked and the vector matches the one stored for it. A combinational `coalesced` status tells the requester whether an assertion presented in the current cycle would be dropped because acknowledges are still outstanding. A rebuild command wipes the tracking state and then walks the destinations one per cycle, re-marking each one that the outside world still reports as unacknowledged. The same rebuild starts by itself if an acknowledge would ever take the count below zero.

The control is a three-state machine. ST_IDLE takes deliveries and acknowledges. ST_WIPE clears the bitmap and the count for one cycle. ST_SCAN visits one destination per cycle. The transitions are: idle-to-wipe on `rebuild_req` or on a would-be underflow; wipe-to-scan always; scan-to-scan while destinations remain; scan-to-idle after the last destination.

Top module: `dat_tracker`

## Requirements
- R1: After reset, `pend_count` is 0, `pend_map` is all zero, `busy` is 0 and `coalesced` is 0 while no inputs are active.
- R2: In idle with a zero count, a `dlv_req` loads `pend_map` with `dlv_mask` and `pend_count` with the number of ones in `dlv_mask` at the next clock edge. The vector `dlv_vector` is stored for every destination whose mask bit is set.
- R3: In idle, `coalesced` is high whenever the count left after any same-cycle acknowledge is nonzero. A `dlv_req` in that cycle changes neither the bitmap nor the count.
- R4: An acknowledge whose `ack_dest` bit is set in `pend_map`, and whose `ack_vector` equals the vector stored for that destination, clears that bit and lowers `pend_count` by one.
- R5: An acknowledge for a destination whose bit is clear, or with a vector that differs from the stored one, leaves `pend_map` and `pend_count` unchanged.
- R6: When an acknowledge and a `dlv_req` arrive in the same idle cycle, the acknowledge is applied first. If it brings the count to zero, `coalesced` is low in that cycle and the delivery is taken.
- R7: `rebuild_req` in idle raises `busy` from the next edge for N+1 cycles (one wipe cycle, then one scan cycle per destination). Afterwards `pend_map` equals the `rebuild_pending` bits seen during the scan, `pend_count` is their population count, and each re-marked destination holds `rebuild_vector`.
- R8: While `busy` is high, `coalesced` is high, and acknowledges and deliveries have no effect on the state that results from the rebuild.
- R9: `pend_count` always equals the number of ones in `pend_map`. A delivery with an empty mask leaves the count at zero, so the next assertion is not coalesced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_req | input | 1 | The tracked pin is asserted this cycle |
| dlv_mask | input | N | Destinations that accepted the delivery |
| dlv_vector | input | VW | Vector sent with the delivery |
| ack_valid | input | 1 | Acknowledge present this cycle |
| ack_dest | input | IW | Index of the acknowledging destination |
| ack_vector | input | VW | Vector being acknowledged |
| rebuild_req | input | 1 | Start a wipe-and-rescan of the tracking state |
| rebuild_pending | input | N | Per-destination "still unacknowledged" condition used during the scan |
| rebuild_vector | input | VW | Vector stored for destinations re-marked by the scan |
| coalesced | output | 1 | An assertion presented this cycle would be dropped |
| busy | output | 1 | Rebuild in progress |
| pend_count | output | CW | Outstanding acknowledge count |
| pend_map | output | N | Destinations still owing an acknowledge |

## Verification
The assertions assume that `ack_dest` is always a valid destination index and that every input is at a known level once reset is released. The stimulus meets both conditions: destination indices are drawn only from 0 to N-1, and all inputs are driven to defined values from time zero. Random acknowledges mostly reuse the vector the bench model holds for the chosen destination, so matching acknowledges are common, and a share carry random vectors so that mismatches are also exercised. The rebuild inputs change freely during a scan, and the reference model samples them in the same cycles as the design.

// File: rtl/dat_pkg.sv
package dat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WIPE = 2'd1,
        ST_SCAN = 2'd2
    } trk_state_e;
endpackage

// File: rtl/dat_ack_match.sv
module dat_ack_match #(
    parameter int N  = 8,
    parameter int VW = 8,
    parameter int IW = 3
) (
    input  logic            ack_valid,
    input  logic [IW-1:0]   ack_dest,
    input  logic [VW-1:0]   ack_vector,
    input  logic [N-1:0]    map,
    input  logic [N*VW-1:0] vec_flat,
    output logic            hit
);
    logic in_range;

    generate
        if (N == (1 << IW)) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = ({1'b0, ack_dest} < (IW+1)'(N));
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        if (ack_valid && in_range && map[ack_dest])
            hit = (vec_flat[ack_dest*VW +: VW] == ack_vector);
    end
endmodule

// File: rtl/dat_vec_store.sv
module dat_vec_store #(
    parameter int N  = 8,
    parameter int VW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    wr_mask,
    input  logic [VW-1:0]   wr_data,
    output logic [N*VW-1:0] vec_flat
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            logic [VW-1:0] slot_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q <= '0;
                else if (wr_mask[g])
                    slot_q <= wr_data;
            end
            assign vec_flat[g*VW +: VW] = slot_q;
        end
    endgenerate
endmodule

// File: rtl/dat_tracker.sv
module dat_tracker #(
    parameter int N  = 8,
    parameter int VW = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1,
    parameter int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dlv_req,
    input  logic [N-1:0]  dlv_mask,
    input  logic [VW-1:0] dlv_vector,
    input  logic          ack_valid,
    input  logic [IW-1:0] ack_dest,
    input  logic [VW-1:0] ack_vector,
    input  logic          rebuild_req,
    input  logic [N-1:0]  rebuild_pending,
    input  logic [VW-1:0] rebuild_vector,
    output logic          coalesced,
    output logic          busy,
    output logic [CW-1:0] pend_count,
    output logic [N-1:0]  pend_map
);
    import dat_pkg::*;

    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    trk_state_e      st_q, st_d;
    logic [IW-1:0]   idx_q, idx_d;
    logic [N-1:0]    map_q, map_d, map_ack;
    logic [CW-1:0]   cnt_q, cnt_d, cnt_ack, mask_pop;
    logic [N-1:0]    wr_mask;
    logic [VW-1:0]   wr_data;
    logic [N*VW-1:0] vec_flat;
    logic            hit;

    dat_ack_match #(.N(N), .VW(VW), .IW(IW)) u_match (
        .ack_valid  (ack_valid),
        .ack_dest   (ack_dest),
        .ack_vector (ack_vector),
        .map        (map_q),
        .vec_flat   (vec_flat),
        .hit        (hit)
    );

    dat_vec_store #(.N(N), .VW(VW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mask  (wr_mask),
        .wr_data  (wr_data),
        .vec_flat (vec_flat)
    );

    always_comb begin
        mask_pop = '0;
        for (int i = 0; i < N; i++)
            mask_pop = mask_pop + CW'(dlv_mask[i]);
    end

    always_comb begin
        map_ack = map_q;
        cnt_ack = cnt_q;
        if (hit) begin
            map_ack[ack_dest] = 1'b0;
            cnt_ack = cnt_q - CW'(1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            map_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            map_q <= map_d;
            cnt_q <= cnt_d;
        end
    end

    // next-state and datapath
    always_comb begin
        st_d    = st_q;
        idx_d   = idx_q;
        map_d   = map_q;
        cnt_d   = cnt_q;
        wr_mask = '0;
        wr_data = dlv_vector;
        unique case (st_q)
            ST_IDLE: begin
                if (rebuild_req) begin
                    st_d = ST_WIPE;
                end else if (hit && cnt_q == '0) begin
                    st_d = ST_WIPE;
                end else begin
                    map_d = map_ack;
                    cnt_d = cnt_ack;
                    if (dlv_req && cnt_ack == '0) begin
                        map_d   = dlv_mask;
                        cnt_d   = mask_pop;
                        wr_mask = dlv_mask;
                    end
                end
            end
            ST_WIPE: begin
                map_d = '0;
                cnt_d = '0;
                idx_d = '0;
                st_d  = ST_SCAN;
            end
            ST_SCAN: begin
                wr_data = rebuild_vector;
                if (rebuild_pending[idx_q]) begin
                    map_d[idx_q]   = 1'b1;
                    cnt_d          = cnt_q + CW'(1);
                    wr_mask[idx_q] = 1'b1;
                end
                if (idx_q == LAST_IDX)
                    st_d = ST_IDLE;
                else
                    idx_d = idx_q + IW'(1);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (st_q != ST_IDLE);
        coalesced  = busy || rebuild_req || (cnt_ack != '0);
        pend_count = cnt_q;
        pend_map   = map_q;
    end
endmodule

// File: rtl/dat_tracker_chk.sv
module dat_tracker_chk #(
    parameter int N  = 8,
    parameter int VW = 8,
    parameter int IW = 3,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dlv_req,
    input logic [N-1:0]  dlv_mask,
    input logic          ack_valid,
    input logic [IW-1:0] ack_dest,
    input logic          rebuild_req,
    input logic          coalesced,
    input logic          busy,
    input logic [CW-1:0] pend_count,
    input logic [N-1:0]  pend_map
);
    // R9
    cnt_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_count == CW'($countones(pend_map)));

    // R3
    coalesced_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count > CW'(1)) |-> coalesced);

    // R8
    busy_coalesced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> coalesced);

    // R2
    deliver_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rebuild_req && !ack_valid && dlv_req && pend_count == '0)
        |=> (pend_map == $past(dlv_mask)));

    // R5
    ack_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rebuild_req && !dlv_req && ack_valid && !pend_map[ack_dest])
        |=> (pend_map == $past(pend_map) && pend_count == $past(pend_count)));

    // R7
    rebuild_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rebuild_req) |=> busy);
endmodule

bind dat_tracker dat_tracker_chk #(.N(N), .VW(VW), .IW(IW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dlv_req     (dlv_req),
    .dlv_mask    (dlv_mask),
    .ack_valid   (ack_valid),
    .ack_dest    (ack_dest),
    .rebuild_req (rebuild_req),
    .coalesced   (coalesced),
    .busy        (busy),
    .pend_count  (pend_count),
    .pend_map    (pend_map)
);

// File: tb/dat_tracker_tb.sv
module dat_tracker_tb;
    localparam int CLK_P = 10;
    localparam int N  = 8;
    localparam int VW = 8;
    localparam int IW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dlv_req = 1'b0;
    logic [N-1:0]  dlv_mask = '0;
    logic [VW-1:0] dlv_vector = '0;
    logic          ack_valid = 1'b0;
    logic [IW-1:0] ack_dest = '0;
    logic [VW-1:0] ack_vector = '0;
    logic          rebuild_req = 1'b0;
    logic [N-1:0]  rebuild_pending = '0;
    logic [VW-1:0] rebuild_vector = '0;
    logic          coalesced, busy;
    logic [CW-1:0] pend_count;
    logic [N-1:0]  pend_map;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model
    logic [N-1:0]  m_map = '0;
    int            m_cnt = 0;
    logic [VW-1:0] m_vec [N];
    int            m_ph = 0;
    int            m_idx = 0;

    always #(CLK_P/2) clk = ~clk;

    dat_tracker #(.N(N), .VW(VW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .dlv_req(dlv_req), .dlv_mask(dlv_mask), .dlv_vector(dlv_vector),
        .ack_valid(ack_valid), .ack_dest(ack_dest), .ack_vector(ack_vector),
        .rebuild_req(rebuild_req), .rebuild_pending(rebuild_pending),
        .rebuild_vector(rebuild_vector),
        .coalesced(coalesced), .busy(busy),
        .pend_count(pend_count), .pend_map(pend_map)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_hit();
        return ack_valid && m_map[ack_dest] && (m_vec[ack_dest] == ack_vector);
    endfunction

    function automatic int pop(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic bit exp_coal();
        int c = m_cnt;
        if (m_ph != 0 || rebuild_req) return 1'b1;
        if (m_hit()) c--;
        return c != 0;
    endfunction

    task automatic clear_in();
        dlv_req = 0; dlv_mask = '0; ack_valid = 0; rebuild_req = 0;
    endtask

    task automatic model_step();
        if (m_ph == 0) begin
            if (rebuild_req) m_ph = 1;
            else begin
                if (m_hit()) begin m_map[ack_dest] = 1'b0; m_cnt--; end
                if (dlv_req && m_cnt == 0) begin
                    m_map = dlv_mask;
                    m_cnt = pop(dlv_mask);
                    for (int i = 0; i < N; i++) if (dlv_mask[i]) m_vec[i] = dlv_vector;
                end
            end
        end else if (m_ph == 1) begin
            m_map = '0; m_cnt = 0; m_idx = 0; m_ph = 2;
        end else begin
            if (rebuild_pending[m_idx]) begin
                m_map[m_idx] = 1'b1; m_cnt++; m_vec[m_idx] = rebuild_vector;
            end
            if (m_idx == N-1) m_ph = 0; else m_idx++;
        end
    endtask

    // inputs are driven just after a falling edge; this checks the
    // combinational status, advances one clock, and checks the state
    task automatic cyc(input string tag);
        #1;
        chk(tag, "coalesced", int'(coalesced), int'(exp_coal()));
        model_step();
        @(negedge clk);
        chk(tag, "pend_map", int'(pend_map), int'(m_map));
        chk(tag, "pend_count", int'(pend_count), m_cnt);
        chk(tag, "busy", int'(busy), int'(m_ph != 0));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) m_vec[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "pend_count", int'(pend_count), 0);
        chk("R1", "pend_map", int'(pend_map), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "coalesced", int'(coalesced), 0);
        @(negedge clk);

        // R2 first delivery
        dlv_req = 1; dlv_mask = 8'b1011_0010; dlv_vector = 8'h41;
        cyc("R2");
        chk("R2", "count4", int'(pend_count), 4);
        clear_in();
        // R3 second assertion coalesced and dropped
        dlv_req = 1; dlv_mask = 8'hff; dlv_vector = 8'h99;
        cyc("R3");
        chk("R3", "map_kept", int'(pend_map), 8'hb2);
        clear_in();
        // R4 matching acknowledge
        ack_valid = 1; ack_dest = 3'd1; ack_vector = 8'h41;
        cyc("R4");
        chk("R4", "count3", int'(pend_count), 3);
        clear_in();
        // R5 acknowledge of clear bit, then wrong vector
        ack_valid = 1; ack_dest = 3'd0; ack_vector = 8'h41;
        cyc("R5");
        ack_dest = 3'd4; ack_vector = 8'h42;
        cyc("R5");
        chk("R5", "map_kept", int'(pend_map), 8'hb0);
        clear_in();
        // R6 retire 4 and 5, then ack 7 alongside a new delivery
        ack_valid = 1; ack_vector = 8'h41; ack_dest = 3'd4; cyc("R4");
        ack_dest = 3'd5; cyc("R4");
        ack_dest = 3'd7; dlv_req = 1; dlv_mask = 8'h0f; dlv_vector = 8'h22;
        #1;
        chk("R6", "coal_low", int'(coalesced), 0);
        cyc("R6");
        chk("R6", "taken", int'(pend_map), 8'h0f);
        clear_in();
        // R9 retire all, then deliver with empty mask
        ack_valid = 1; ack_vector = 8'h22;
        for (int d = 0; d < 4; d++) begin ack_dest = IW'(d); cyc("R4"); end
        clear_in();
        dlv_req = 1; dlv_mask = '0; dlv_vector = 8'h10;
        cyc("R9");
        clear_in();
        #1;
        chk("R9", "not_coalesced", int'(coalesced), 0);
        // R7 and R8 rebuild with traffic while busy
        rebuild_req = 1; rebuild_pending = 8'h5a; rebuild_vector = 8'h77;
        cyc("R7");
        rebuild_req = 0;
        for (int k = 0; k < N + 1; k++) begin
            ack_valid = 1; ack_dest = IW'(k % N); ack_vector = 8'h77;
            dlv_req = 1; dlv_mask = 8'hff;
            #1;
            chk("R8", "coal_busy", int'(coalesced), 1);
            cyc("R8");
        end
        clear_in();
        chk("R7", "map", int'(pend_map), 8'h5a);
        chk("R7", "count", int'(pend_count), 4);
        chk("R7", "idle", int'(busy), 0);
        ack_valid = 1; ack_dest = 3'd1; ack_vector = 8'h77;
        cyc("R7");
        chk("R7", "vec_restored", int'(pend_map), 8'h58);
        clear_in();

        // constrained random traffic
        for (int t = 0; t < 600; t++) begin
            dlv_req = ($urandom_range(0, 3) == 0);
            dlv_mask = N'($urandom);
            dlv_vector = VW'($urandom);
            ack_valid = ($urandom_range(0, 1) == 1);
            ack_dest = IW'($urandom_range(0, N-1));
            ack_vector = ($urandom_range(0, 9) < 7) ? m_vec[ack_dest] : VW'($urandom);
            rebuild_req = ($urandom_range(0, 39) == 0);
            rebuild_pending = N'($urandom);
            rebuild_vector = VW'($urandom);
            cyc("R9");
        end
        clear_in();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule